// File: doc/BRIEF.md
# Four-Bit Control-Sliced ALU

This block is a purely combinational 4-bit arithmetic and logic unit for two's-complement operands. Its datapath does not decode an operation internally. Instead it is steered by five independent control bits:

- a two-bit result select;
- an adder carry-in;
- a B-operand invert;
- an A-operand zero force.

From these bits it produces sum, difference, bitwise AND, bitwise OR and the two's-complement negation of B. Negation reuses the adder: A is forced to zero, B is inverted and a carry-in of one is added. No separate negator exists.

A thin decoder sits in front of the datapath core. It turns a three-bit operation code into the control vector and drives every don't-care control bit low. The result, the adder carry-out and a signed-overflow flag appear in the same cycle the inputs change. There is no state, no clock and no latency inside the block.

Top module: `alu4_op_top`

## Requirements
- R1: Op code 0 gives r_o = (a_i + b_i) mod 16, with cout_o equal to bit 4 of the unsigned sum.
- R2: Op code 1 gives r_o = (a_i - b_i) mod 16, formed as a_i + ~b_i + 1. cout_o is 1 exactly when a_i >= b_i as unsigned values.
- R3: Op code 2 gives r_o = a_i | b_i, and op code 3 gives r_o = a_i & b_i. cout_o and ovf_o are 0 for both.
- R4: Op code 4 gives r_o = (-b_i) mod 16, and a_i has no effect on any output. cout_o is 1 only when b_i = 0.
- R5: For op codes 0, 1 and 4, ovf_o is 1 exactly when the signed result of the operation lies outside -8..7. For example, 0111 + 0001 and 1000 - 0001 both overflow.
- R6: Negating b_i = 1000 gives r_o = 1000 with ovf_o = 1.
- R7: Subtracting equal operands gives r_o = 0000 with cout_o = 1 and ovf_o = 0.
- R8: Op codes 5, 6 and 7 select the zero result: r_o = 0000, cout_o = 0 and ovf_o = 0, whatever the operands are.
- R9: All outputs are a combinational function of the current inputs, settled within the cycle in which those inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Operand A, two's complement |
| b_i | input | 4 | Operand B, two's complement |
| op_i | input | 3 | Operation code: 0 add, 1 sub, 2 OR, 3 AND, 4 negate B, 5-7 zero |
| r_o | output | 4 | Result |
| cout_o | output | 1 | Adder carry out of bit 3; 0 for logic and zero selects |
| ovf_o | output | 1 | Signed overflow; 0 for logic and zero selects |

## Verification
A stuck or miswired control bit, such as an inverted B during OR or a carry-in that is lost on subtract, corrupts r_o, cout_o or ovf_o for the very input pattern that reaches it. The error appears in the same cycle, because no register lies between inputs and outputs. Every op code is therefore swept over all 256 operand pairs. This exposes any wrong bit of the decoder's control vector and any broken stage of the carry chain. Directed vectors add coverage where the flags are easy to get wrong: negating -8, subtracting equal values, and the signed edges 7+1 and -8-1.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  parameter int unsigned DW  = 4;
  localparam int unsigned OPW = 3;

  typedef enum logic [1:0] {
    SEL_SUM  = 2'b00,
    SEL_AND  = 2'b01,
    SEL_OR   = 2'b10,
    SEL_ZERO = 2'b11
  } res_sel_e;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_OR  = 3'd2,
    OP_AND = 3'd3,
    OP_NEG = 3'd4
  } op_e;

  typedef struct packed {
    res_sel_e sel;
    logic     cin;
    logic     binv;
    logic     az;
  } ctrl_t;
endpackage

// File: rtl/alu4_ctrl_dec.sv
module alu4_ctrl_dec
  import alu4_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  output ctrl_t          ctrl_o
);
  always_comb begin
    // don't-care bits driven low
    ctrl_o = '{sel: SEL_ZERO, cin: 1'b0, binv: 1'b0, az: 1'b0};
    case (op_i)
      OP_ADD: ctrl_o.sel = SEL_SUM;
      OP_SUB: begin
        ctrl_o.sel  = SEL_SUM;
        ctrl_o.cin  = 1'b1;
        ctrl_o.binv = 1'b1;
      end
      OP_OR:  ctrl_o.sel = SEL_OR;
      OP_AND: ctrl_o.sel = SEL_AND;
      OP_NEG: begin
        ctrl_o.sel  = SEL_SUM;
        ctrl_o.cin  = 1'b1;
        ctrl_o.binv = 1'b1;
        ctrl_o.az   = 1'b1;
      end
      default: ctrl_o.sel = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/alu4_operand_prep.sv
module alu4_operand_prep #(
  parameter int unsigned DW = alu4_pkg::DW
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          az_i,
  input  logic          binv_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o
);
  assign a_o = az_i ? '0 : a_i;
  assign b_o = b_i ^ {DW{binv_i}};
endmodule

// File: rtl/alu4_ripple_add.sv
module alu4_ripple_add #(
  parameter int unsigned DW = alu4_pkg::DW
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          ovf_o
);
  logic [DW:0] c;
  assign c[0] = cin_i;

  for (genvar g = 0; g < DW; g++) begin : g_fa
    assign sum_o[g] = a_i[g] ^ b_i[g] ^ c[g];
    assign c[g+1]   = (a_i[g] & b_i[g]) | (c[g] & (a_i[g] ^ b_i[g]));
  end

  assign cout_o = c[DW];
  // same-sign operands, different-sign sum
  assign ovf_o  = (a_i[DW-1] ~^ b_i[DW-1]) & (sum_o[DW-1] ^ a_i[DW-1]);
endmodule

// File: rtl/alu4_logic_unit.sv
module alu4_logic_unit #(
  parameter int unsigned DW = alu4_pkg::DW
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] and_o,
  output logic [DW-1:0] or_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
endmodule

// File: rtl/alu4_core.sv
module alu4_core
  import alu4_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  ctrl_t        ctrl_i,
  output logic [W-1:0] r_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] a_eff, b_eff, sum, and_r, or_r;
  logic         add_co, add_ov;

  alu4_operand_prep #(.DW(W)) u_prep (
    .a_i(a_i), .b_i(b_i), .az_i(ctrl_i.az), .binv_i(ctrl_i.binv),
    .a_o(a_eff), .b_o(b_eff)
  );

  alu4_ripple_add #(.DW(W)) u_add (
    .a_i(a_eff), .b_i(b_eff), .cin_i(ctrl_i.cin),
    .sum_o(sum), .cout_o(add_co), .ovf_o(add_ov)
  );

  alu4_logic_unit #(.DW(W)) u_logic (
    .a_i(a_eff), .b_i(b_eff), .and_o(and_r), .or_o(or_r)
  );

  always_comb begin
    r_o    = '0;
    cout_o = 1'b0;
    ovf_o  = 1'b0;
    case (ctrl_i.sel)
      SEL_SUM: begin
        r_o    = sum;
        cout_o = add_co;
        ovf_o  = add_ov;
      end
      SEL_AND: r_o = and_r;
      SEL_OR:  r_o = or_r;
      default: r_o = '0;
    endcase
  end

  // checks across prep/adder/mux
  always_comb begin
    if (ctrl_i.sel != SEL_SUM)
      AST_LOGIC_NO_FLAGS: assert (!cout_o && !ovf_o); // R3
    if (ctrl_i.sel == SEL_ZERO)
      AST_ZERO_SEL: assert (r_o == '0); // R8
    if (ctrl_i.sel == SEL_SUM && !ctrl_i.az && !ctrl_i.binv && !ctrl_i.cin)
      AST_ADD_SUM: assert ({cout_o, r_o} == ({1'b0, a_i} + {1'b0, b_i})); // R1
    if (ctrl_i.sel == SEL_SUM && ctrl_i.az && ctrl_i.binv && ctrl_i.cin)
      AST_NEG_VALUE: assert (r_o == W'(-b_i)); // R4
    if (ctrl_i.sel == SEL_SUM && !ctrl_i.az && ctrl_i.binv && ctrl_i.cin && a_i == b_i)
      AST_SUB_EQUAL: assert (r_o == '0 && cout_o && !ovf_o); // R7
  end
endmodule

// File: rtl/alu4_op_top.sv
module alu4_op_top
  import alu4_pkg::*;
(
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [OPW-1:0] op_i,
  output logic [DW-1:0]  r_o,
  output logic           cout_o,
  output logic           ovf_o
);
  ctrl_t ctrl;

  alu4_ctrl_dec u_dec (.op_i(op_i), .ctrl_o(ctrl));

  alu4_core #(.W(DW)) u_core (
    .a_i(a_i), .b_i(b_i), .ctrl_i(ctrl),
    .r_o(r_o), .cout_o(cout_o), .ovf_o(ovf_o)
  );

  always_comb begin
    if (op_i > 3'd4)
      AST_HIGH_OP_ZERO: assert (r_o == '0 && !cout_o && !ovf_o); // R8
  end
endmodule

// File: tb/alu4_op_top_tb_top.sv
module alu4_op_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 20000;

  typedef struct {
    logic [2:0] op;
    logic [3:0] a, b, r;
    logic       co, ov;
    int         req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] a_i = '0, b_i = '0;
  logic [2:0] op_i = '0;
  logic [3:0] r_o;
  logic       cout_o, ovf_o;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu4_op_top dut_i (
    .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .r_o(r_o), .cout_o(cout_o), .ovf_o(ovf_o)
  );

  function automatic int sx(logic [3:0] v);
    return v[3] ? int'(v) - 16 : int'(v);
  endfunction

  // reference model from requirements
  function automatic item_t model(logic [2:0] op, logic [3:0] a, logic [3:0] b, int req);
    item_t it;
    int s;
    it.op = op; it.a = a; it.b = b; it.req = req;
    it.co = 1'b0; it.ov = 1'b0; it.r = '0;
    case (op)
      3'd0: begin // R1, R5
        it.r = 4'(int'(a) + int'(b));
        it.co = (int'(a) + int'(b)) > 15;
        s = sx(a) + sx(b); it.ov = (s > 7) || (s < -8);
      end
      3'd1: begin // R2, R5, R7
        it.r = 4'(int'(a) - int'(b));
        it.co = a >= b;
        s = sx(a) - sx(b); it.ov = (s > 7) || (s < -8);
      end
      3'd2: it.r = a | b;   // R3
      3'd3: it.r = a & b;   // R3
      3'd4: begin // R4, R6
        it.r = 4'(-int'(b));
        it.co = (b == 0);
        s = -sx(b); it.ov = (s > 7);
      end
      default: it.r = '0;   // R8
    endcase
    return it;
  endfunction

  task automatic drive(logic [2:0] op, logic [3:0] a, logic [3:0] b, int req);
    @(posedge clk);
    op_i <= op; a_i <= a; b_i <= b;
    q.push_back(model(op, a, b, req));
  endtask

  // monitor: half cycle after drive (R9: no latency)
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      total++;
      if (r_o !== e.r || cout_o !== e.co || ovf_o !== e.ov) begin
        bad++;
        $display("FAIL R%0d op=%0d a=%h b=%h got r=%h co=%b ov=%b exp r=%h co=%b ov=%b",
                 e.req, e.op, e.a, e.b, r_o, cout_o, ovf_o, e.r, e.co, e.ov);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_CYC && !done) begin
      bad++; total++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + CLK_PERIOD / 4);
    // reset state: zero inputs, add -> all outputs zero (R1, R9)
    total++;
    if (r_o !== 4'h0 || cout_o !== 1'b0 || ovf_o !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset state got r=%h co=%b ov=%b exp r=0 co=0 ov=0", r_o, cout_o, ovf_o);
    end
    rst_ni = 1'b1;

    // directed corners
    drive(3'd0, 4'h7, 4'h1, 5);  // R5 7+1 overflow
    drive(3'd1, 4'h8, 4'h1, 5);  // R5 -8-1 overflow
    drive(3'd4, 4'h8, 4'h8, 6);  // R6 negate -8
    drive(3'd4, 4'h3, 4'h0, 4);  // R4 negate zero, carry 1
    drive(3'd4, 4'hF, 4'h5, 4);  // R4 a ignored
    drive(3'd1, 4'h6, 4'h6, 7);  // R7 equal subtract
    drive(3'd1, 4'h0, 4'h0, 7);  // R7
    drive(3'd2, 4'hA, 4'h5, 3);  // R3 OR
    drive(3'd3, 4'hC, 4'hA, 3);  // R3 AND
    drive(3'd0, 4'hF, 4'hF, 1);  // R1 carry out
    drive(3'd5, 4'hF, 4'hF, 8);  // R8
    drive(3'd7, 4'h9, 4'h7, 8);  // R8

    // exhaustive sweep, tag per op (R1 R2 R3 R4 R8)
    for (int op = 0; op < 8; op++) begin
      for (int ab = 0; ab < 256; ab++) begin
        int rq;
        rq = (op == 0) ? 1 : (op == 1) ? 2 : (op < 4) ? 3 : (op == 4) ? 4 : 8;
        drive(3'(op), 4'(ab >> 4), 4'(ab), rq);
      end
    end

    // R9: back-to-back changing ops, each checked the same cycle
    drive(3'd0, 4'h1, 4'h2, 9);
    drive(3'd1, 4'h1, 4'h2, 9);
    drive(3'd2, 4'h1, 4'h2, 9);

    wait (q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule